// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Full Flag

This block is a first-in/first-out buffer of 9-bit words, modelled synchronously on one system clock. Producers and consumers signal transfers with active-low strobes: the falling edge of the write strobe stores a word, and the falling edge of the read strobe pops the oldest word. Each strobe is sampled on the clock and compared with its previous sample to find its edges. All nine bits are kept unchanged, so the top bit can carry parity or a control marker.

Three active-low flags report occupancy: empty, full and half-full. An edge on a strobe does nothing while the flag that guards it is asserted. This lets the buffer stand in a data path with no further handshake. The read-data bus carries a separate output-enable that models a bus driver. Outside a read, the enable is low and the bus is all zeros.

An active-low rewind input moves the read pointer back to location zero and leaves the write pointer where it is. Everything written since reset can then be read again, provided fewer words than the depth were written. The strobes have no back-pressure of their own. A producer must watch the full flag, and a consumer must watch the empty flag, because a blocked strobe edge is dropped silently.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low, both pointers and the occupancy are zero, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0. The block stays in this state after `rst_n` rises until a strobe acts.
- R2: A write happens when `wr_n` is sampled low on a clock edge after being sampled high on the edge before, and `full_n` is 1. The word on `din` is stored at that edge. The flags show the new state from the next clock cycle on.
- R3: A read happens when `rd_n` is sampled low after being sampled high, and `empty_n` is 1. The oldest stored word appears on `dout`, with `dout_oe`=1, in the cycle after that edge. Words leave in the order they were written.
- R4: `empty_n` is 0 exactly when the occupancy is zero. `full_n` is 0 exactly when the occupancy equals the depth. They are never both 0.
- R5: `half_n` goes to 0 on the write that raises the occupancy above half the depth. It returns to 1 only on the clock edge where `rd_n` is first sampled high again after a read, and only if the occupancy is then at most half the depth. It stays 0 while `rd_n` is held low.
- R6: While `rt_n` is low, the read pointer is set to zero and the write pointer does not change. The occupancy becomes the write pointer value, and the flags are recomputed from it. The next read then returns the first word written since reset.
- R7: Strobe edges are ignored during reset and while `rt_n` is low. A strobe that is still low when reset or rewind ends causes no transfer until it goes high and falls again.
- R8: `dout_oe` is 1 only from the cycle after a valid read edge until `rd_n` is sampled high. Whenever `dout_oe` is 0, `dout` is all zeros. A read edge while the buffer is empty leaves `dout_oe` at 0.
- R9: Bit 8 of each word, like bits 7..0, is returned exactly as it was written.
- R10: When write and read edges fall on the same clock edge and the buffer is neither empty nor full, both transfers take place and the occupancy does not change. A write edge that arrives while the buffer is full is dropped, and no stored word is overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe; falling edge stores `din` |
| rd_n | input | 1 | Active-low read strobe; falling edge pops a word |
| rt_n | input | 1 | Active-low rewind; read pointer to location zero |
| din | input | 9 | Write data word |
| dout | output | 9 | Read data word; zero while not enabled |
| dout_oe | output | 1 | Read-data output enable (bus-driver model) |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| half_n | output | 1 | Active-low more-than-half-full flag |

## Verification
The bench builds the block with a 3-bit address, which gives eight locations. The full boundary is then reached after eight writes. The half-full threshold lies between four and five words. The pointers wrap within a short stimulus table, so writes that are dropped while the buffer is full and wrapped reads are both exercised. The default 16-entry build is only elaborated. The rewind is exercised with an occupancy above half the depth, so the recomputed half-full flag is checked as well as the pointer.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  // Internal active-high flag bundle; the top inverts to active-low pins.
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } fifo_flags_t;

  localparam fifo_flags_t FLAGS_AT_RESET = '{empty: 1'b1, full: 1'b0, half: 1'b0};

endpackage

// File: rtl/fifo_rt_edge.sv
// Samples a group of active-low strobes and reports their edges.
// While hold is high the edges are masked, but the samples keep tracking,
// so a strobe that went low during hold yields no edge afterwards.
module fifo_rt_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_stb
    // Reset to "seen low" so a strobe held low across reset gives no fall.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= strobe_n[i];
    end

    assign fall[i] = !hold &&  prev_q[i] && !strobe_n[i];
    assign rise[i] = !hold && !prev_q[i] &&  strobe_n[i];
  end

endmodule

// File: rtl/fifo_rt_store.sv
// Storage array: one synchronous write port, one combinational read port.
module fifo_rt_store #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_rt_ctrl.sv
// Pointer, occupancy and flag control.
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          rd_rise,
  input  logic          rewind,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output fifo_flags_t   flags
);

  localparam int            DEPTH  = 1 << AW;
  localparam int            CW     = AW + 1;
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_nx;
  logic [CW-1:0] wp_as_count;

  // Transfers are gated by the registered flags of this cycle.
  assign wr_en = wr_fall && !flags.full  && !rewind;
  assign rd_en = rd_fall && !flags.empty && !rewind;

  assign count_nx    = count_q + CW'(wr_en) - CW'(rd_en);
  assign wp_as_count = {1'b0, wr_ptr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      flags   <= FLAGS_AT_RESET;
    end else if (rewind) begin
      rd_ptr      <= '0;
      count_q     <= wp_as_count;
      flags.empty <= (wp_as_count == '0);
      flags.full  <= 1'b0;
      flags.half  <= (wp_as_count > HALF_C);
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      count_q     <= count_nx;
      flags.empty <= (count_nx == '0);
      flags.full  <= (count_nx == FULL_C);
      // Half-full sets on a write crossing the midpoint, clears on read release.
      if (wr_en && (count_nx > HALF_C))
        flags.half <= 1'b1;
      else if (rd_rise && (count_nx <= HALF_C))
        flags.half <= 1'b0;
    end
  end

endmodule

// File: rtl/fifo_rt.sv
// Strobe-driven FIFO with rewind and half-full flag (top).
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);

  localparam int STB_WR = 0;
  localparam int STB_RD = 1;

  logic [1:0]        stb_fall;
  logic [1:0]        stb_rise;
  logic              rewind;
  logic              wr_en;
  logic              rd_en;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] dout_q;
  logic              oe_q;
  fifo_flags_t       flags;

  assign rewind = !rt_n;

  fifo_rt_edge #(.N(2)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (rewind),
    .strobe_n ({rd_n, wr_n}),
    .fall     (stb_fall),
    .rise     (stb_rise)
  );

  fifo_rt_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fall (stb_fall[STB_WR]),
    .rd_fall (stb_fall[STB_RD]),
    .rd_rise (stb_rise[STB_RD]),
    .rewind  (rewind),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .flags   (flags)
  );

  fifo_rt_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (din),
    .raddr (rd_ptr),
    .rdata (mem_rdata)
  );

  // Output stage: capture on a valid read, drop enable when the strobe is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else if (rd_en) begin
      dout_q <= mem_rdata;
      oe_q   <= 1'b1;
    end else if (rd_n || rewind) begin
      oe_q   <= 1'b0;
    end
  end

  assign dout    = oe_q ? dout_q : '0;
  assign dout_oe = oe_q;
  assign empty_n = !flags.empty;
  assign full_n  = !flags.full;
  assign half_n  = !flags.half;

endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic          dout_oe,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] wr_ptr
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!empty_n && full_n && half_n && !dout_oe));                // R1

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_n && rt_n) |=> !full_n);                                      // R2

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_n && rt_n) |=> !empty_n);                                    // R3

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));                                                     // R4

  AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> half_n);                                                        // R5

  AST_REWIND_READ_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rd_ptr == '0));                                                   // R6

  AST_REWIND_WRITE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> $stable(wr_ptr));                                                  // R7

  AST_OE_AFTER_RD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !$past(rd_n));                                                   // R8

endmodule

bind fifo_rt fifo_rt_chk #(.AW(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_n    (wr_n),
  .rd_n    (rd_n),
  .rt_n    (rt_n),
  .dout_oe (dout_oe),
  .empty_n (empty_n),
  .full_n  (full_n),
  .half_n  (half_n),
  .rd_ptr  (rd_ptr),
  .wr_ptr  (wr_ptr)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;

  localparam int AW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_oe;
  logic       empty_n;
  logic       full_n;
  logic       half_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fifo_rt #(.ADDR_W(AW), .DATA_W(9)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_BOTH = 2'd2;

  // flags field order: {empty_n, full_n, half_n}
  typedef struct packed {
    logic [1:0] op;
    logic [8:0] data;
    logic [8:0] exp_q;
    logic       exp_oe;
    logic [2:0] exp_flags;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   9'h101, 9'h000, 1'b0, 3'b111},
    '{OP_WR,   9'h0A2, 9'h000, 1'b0, 3'b111},
    '{OP_WR,   9'h1C3, 9'h000, 1'b0, 3'b111},
    '{OP_WR,   9'h004, 9'h000, 1'b0, 3'b111},
    '{OP_WR,   9'h155, 9'h000, 1'b0, 3'b110},  // R5 crosses half
    '{OP_RD,   9'h000, 9'h101, 1'b1, 3'b111},  // R5 clears on release
    '{OP_BOTH, 9'h0E6, 9'h0A2, 1'b1, 3'b111},  // R10
    '{OP_WR,   9'h1F7, 9'h000, 1'b0, 3'b110},
    '{OP_WR,   9'h008, 9'h000, 1'b0, 3'b110},
    '{OP_WR,   9'h199, 9'h000, 1'b0, 3'b110},
    '{OP_WR,   9'h0AA, 9'h000, 1'b0, 3'b100},  // R2 full
    '{OP_WR,   9'h1BB, 9'h000, 1'b0, 3'b100},  // R10 dropped
    '{OP_RD,   9'h000, 9'h1C3, 1'b1, 3'b110},
    '{OP_RD,   9'h000, 9'h004, 1'b1, 3'b110},
    '{OP_RD,   9'h000, 9'h155, 1'b1, 3'b110},
    '{OP_RD,   9'h000, 9'h0E6, 1'b1, 3'b111},
    '{OP_RD,   9'h000, 9'h1F7, 1'b1, 3'b111},
    '{OP_RD,   9'h000, 9'h008, 1'b1, 3'b111},
    '{OP_RD,   9'h000, 9'h199, 1'b1, 3'b111},
    '{OP_RD,   9'h000, 9'h0AA, 1'b1, 3'b011},  // R4 empty
    '{OP_RD,   9'h000, 9'h000, 1'b0, 3'b011}   // R3 empty read ignored
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [2:0] exp);
    check({empty_n, full_n, half_n} === exp, req, "flags {e,f,h}",
          int'({empty_n, full_n, half_n}), int'(exp));
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] d);
    din  = d;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic [8:0] exp);
    rd_n = 1'b0;
    @(negedge clk);
    check(dout_oe === 1'b1 && dout === exp, req, "read word", int'(dout), int'(exp));
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    // R1: state during and just after reset
    @(negedge clk);
    chk_flags("R1", 3'b011);
    check(dout_oe === 1'b0, "R1", "oe in reset", int'(dout_oe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_flags("R1", 3'b011);
    check(dout === 9'h000, "R1", "dout after reset", int'(dout), 0);

    // Table walk: R2 R3 R4 R5 R9 R10
    for (int i = 0; i < NV; i++) begin
      din  = VECS[i].data;
      wr_n = !(VECS[i].op == OP_WR || VECS[i].op == OP_BOTH);
      rd_n = !(VECS[i].op == OP_RD || VECS[i].op == OP_BOTH);
      @(negedge clk);
      if (VECS[i].op != OP_WR) begin
        check(dout_oe === VECS[i].exp_oe, "R8", "oe while rd low",
              int'(dout_oe), int'(VECS[i].exp_oe));
        check(dout === VECS[i].exp_q, "R3 R9", "read word",
              int'(dout), int'(VECS[i].exp_q));
      end
      wr_n = 1'b1;
      rd_n = 1'b1;
      @(negedge clk);
      chk_flags("R2 R4 R5 R10", VECS[i].exp_flags);
      check(dout_oe === 1'b0 && dout === 9'h000, "R8", "bus off after release",
            int'(dout), 0);
    end

    // R5: half-full held while strobe low, cleared on release
    do_reset();
    for (int i = 0; i < 5; i++) do_write(9'h100 + 9'(i));
    chk_flags("R5", 3'b110);
    rd_n = 1'b0;
    @(negedge clk);
    check(dout === 9'h100, "R5", "first word", int'(dout), 32'h100);
    check(half_n === 1'b0, "R5", "half held while rd low", int'(half_n), 0);
    rd_n = 1'b1;
    @(negedge clk);
    check(half_n === 1'b1, "R5", "half cleared on release", int'(half_n), 1);

    // R6 R7: drain, then rewind with a read strobe held low
    for (int i = 1; i < 5; i++) do_read("R3", 9'h100 + 9'(i));
    chk_flags("R4", 3'b011);
    rd_n = 1'b0;
    rt_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rt_n = 1'b1;
    @(negedge clk);
    chk_flags("R6", 3'b110);
    check(dout_oe === 1'b0, "R7", "held strobe after rewind", int'(dout_oe), 0);
    @(negedge clk);
    chk_flags("R7", 3'b110);
    rd_n = 1'b1;
    @(negedge clk);
    do_read("R6", 9'h100);
    do_read("R6", 9'h101);
    chk_flags("R6", 3'b111);

    // R7: write strobe held low across reset release
    wr_n = 1'b0;
    din  = 9'h1FF;
    do_reset();
    @(negedge clk);
    chk_flags("R7", 3'b011);
    wr_n = 1'b1;
    @(negedge clk);
    do_write(9'h1FF);
    chk_flags("R2", 3'b111);
    do_read("R9", 9'h1FF);

    // R1: reset in mid-run empties the buffer
    do_write(9'h033);
    do_write(9'h044);
    do_reset();
    chk_flags("R1", 3'b011);
    rd_n = 1'b0;
    @(negedge clk);
    check(dout_oe === 1'b0, "R1", "no data after reset", int'(dout_oe), 0);
    rd_n = 1'b1;
    @(negedge clk);

    finish_up();
  end

endmodule